// File: doc/BRIEF.md
# Shared Timebase Counter with Per-Core Compare Interrupts

This block keeps one free-running up-counter that every core in a cluster shares as a common timebase. The counter is 32 + 4·N bits wide, where N is a build-time width code. Software reads it as two 32-bit words. The reads are not atomic, so software reads the upper word, then the lower word, then the upper word again, and retries if the two upper reads differ. A halt bit in the configuration word freezes the count and clearing that bit lets it run on from the held value.

Each core owns a 64-bit compare value, written and read back as two 32-bit words (upper first, then lower). When the counter reaches or passes a core's compare value, that core's interrupt line rises. The line stays high until the lower compare word of that core is written again. A core reaches its own compare through local addresses. It can reach any other core's compare through a peer window, after it has written the target core number into its own peer-select word. Every access carries the number of the requesting core. The read data is combinational from the address, the core number and the current state. Writes take effect at the clock edge where the write strobe is high.

Top module: `shared_timebase`

## Requirements
- R1: After reset the counter is zero and running, the halt bit is 0, every compare value is all ones (both words read 0xFFFFFFFF), every interrupt line is low and every peer-select word reads 0.
- R2: While not halted, the counter advances by exactly one per clock cycle and wraps to zero at 2^(32+4·N).
- R3: Address 1 reads counter bits 31..0 and address 2 reads counter bits 63..32; bits at or above the counter width read as zero.
- R4: Address 0 is the configuration word: bit 0 is the halt bit (read/write), bits 7..4 read the width code N, and every other bit reads zero whatever was written.
- R5: A write with bit 0 set halts the counter from the next cycle on and the value holds; a write with bit 0 clear resumes counting from the held value.
- R6: Address 3 (lower word) and address 4 (upper word) write and read the compare value of the requesting core only.
- R7: Address 5 holds the requesting core's peer-select (values below the core count are accepted, others are ignored); addresses 6 (lower) and 7 (upper) write and read the compare value of the selected core.
- R8: A core's interrupt line is high from the cycle after the counter is greater than or equal to that core's compare value, and it stays low while the counter is below it.
- R9: Once high, a core's interrupt line stays high until its lower compare word is written (locally or through the peer window); the line is low in the cycle after that write, then reflects the new compare. A write to the upper word alone does not clear it.
- R10: Writes to the counter addresses 1 and 2 change nothing: the counter value is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCore | input | CORE_W | Number of the core making the access |
| busAddr | input | 3 | Word address of the access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr and busCore |
| cmpIrq | output | NUM_CORES | Compare interrupt, one line per core |

## Verification
A counter that skips or stalls shows as a wrong difference between two lower-word reads a known number of cycles apart. It is visible at the first read after the fault. A halt bit that is stuck or mis-latched shows within one read, because the held value either drifts or fails to resume with the exact offset. A compare register that belongs to the wrong core, or a peer select that decodes badly, shows on readback. It also shows as an interrupt on the wrong line one cycle after the write. A wrong clear or set rule shows on the interrupt line in the single cycle after a lower-word write, while the counter is halted so that every expected level is exact.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG     = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEER    = 3'd5;
  localparam logic [ADDR_W-1:0] A_PCMP_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_PCMP_HI = 3'd7;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CFG,
    RD_CNT_LO,
    RD_CNT_HI,
    RD_CMP_LO,
    RD_CMP_HI,
    RD_PEER
  } rdSel_e;

  typedef struct packed {
    logic   cfgWr;
    logic   cmpLoWr;
    logic   cmpHiWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [CORE_W-1:0]          busCore,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWr,
  input  logic [31:0]                busWrData,
  output ctrlStrobe_t                strobe,
  output logic [CORE_W-1:0]          tgtCore,
  output logic [CORE_W-1:0]          peerRd
);

  logic [NUM_CORES-1:0][CORE_W-1:0] peerSel;
  logic coreOk;
  logic peerValOk;
  logic peerWr;
  logic [CORE_W-1:0] ownPeer;

  assign coreOk    = (32'(busCore) < 32'(NUM_CORES));
  assign peerValOk = (busWrData < 32'(NUM_CORES));
  assign ownPeer   = coreOk ? peerSel[busCore] : '0;
  assign peerRd    = ownPeer;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    tgtCore      = busCore;
    peerWr       = 1'b0;
    if (coreOk) begin
      case (busAddr)
        A_CFG: begin
          strobe.cfgWr = busWr;
          strobe.rdSel = RD_CFG;
        end
        A_CNT_LO: strobe.rdSel = RD_CNT_LO;
        A_CNT_HI: strobe.rdSel = RD_CNT_HI;
        A_CMP_LO: begin
          strobe.cmpLoWr = busWr;
          strobe.rdSel   = RD_CMP_LO;
        end
        A_CMP_HI: begin
          strobe.cmpHiWr = busWr;
          strobe.rdSel   = RD_CMP_HI;
        end
        A_PEER: begin
          peerWr       = busWr;
          strobe.rdSel = RD_PEER;
        end
        A_PCMP_LO: begin
          tgtCore        = ownPeer;
          strobe.cmpLoWr = busWr;
          strobe.rdSel   = RD_CMP_LO;
        end
        A_PCMP_HI: begin
          tgtCore        = ownPeer;
          strobe.cmpHiWr = busWr;
          strobe.rdSel   = RD_CMP_HI;
        end
        default: strobe.rdSel = RD_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peerSel <= '0;
    end else if (peerWr && peerValOk) begin
      peerSel[busCore] <= busWrData[CORE_W-1:0];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cfgWr, strobe.cmpLoWr, strobe.cmpHiWr, peerWr})) else $error("strobe clash"); // R6

  AST_PEER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (32'(ownPeer) < 32'(NUM_CORES))) else $error("peer select out of range"); // R7

endmodule

// File: rtl/timebase_datapath.sv
module timebase_datapath
  import timebase_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int CORE_W     = 2,
  parameter int WIDTH_CODE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [CORE_W-1:0]     tgtCore,
  input  logic [CORE_W-1:0]     peerRd,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic [NUM_CORES-1:0]  irq
);

  localparam int CNT_W = 32 + 4 * WIDTH_CODE;

  logic [CNT_W-1:0]                 count;
  logic [63:0]                      countExt;
  logic                             halt;
  logic [NUM_CORES-1:0][63:0]       cmpReg;
  logic [NUM_CORES-1:0]             irqReg;
  logic [NUM_CORES-1:0]             loHit;
  logic [NUM_CORES-1:0]             reached;
  logic [63:0]                      tgtCmp;

  assign countExt = 64'(count);
  assign irq      = irqReg;
  assign tgtCmp   = cmpReg[tgtCore];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      halt  <= 1'b0;
    end else begin
      if (!halt) count <= count + CNT_W'(1);
      if (strobe.cfgWr) halt <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '1;
      irqReg <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (strobe.cmpHiWr && tgtCore == CORE_W'(c)) cmpReg[c][63:32] <= wrData;
        if (loHit[c]) cmpReg[c][31:0] <= wrData;
        irqReg[c] <= loHit[c] ? 1'b0 : (irqReg[c] | reached[c]);
      end
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    assign loHit[g]   = strobe.cmpLoWr && (tgtCore == CORE_W'(g));
    assign reached[g] = (countExt >= cmpReg[g]);

    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (reached[g] && !loHit[g]) |=> irqReg[g]) else $error("irq missed"); // R8

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      loHit[g] |=> !irqReg[g]) else $error("irq not cleared"); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (irqReg[g] && !loHit[g]) |=> irqReg[g]) else $error("irq dropped"); // R9
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CFG:    rdData = {24'd0, 4'(WIDTH_CODE), 3'd0, halt};
      RD_CNT_LO: rdData = countExt[31:0];
      RD_CNT_HI: rdData = countExt[63:32];
      RD_CMP_LO: rdData = tgtCmp[31:0];
      RD_CMP_HI: rdData = tgtCmp[63:32];
      RD_PEER:   rdData = 32'(peerRd);
      default:   rdData = '0;
    endcase
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (count == $past(count))) else $error("count moved while halted"); // R5

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !halt |=> (count == $past(count) + CNT_W'(1))) else $error("count step wrong"); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_CNT_HI) |-> ((rdData >> (CNT_W - 32)) == 32'd0)) else $error("upper bits set"); // R3

endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
  import timebase_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int WIDTH_CODE = 8,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CORE_W-1:0]     busCore,
  input  logic [2:0]            busAddr,
  input  logic                  busWr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic [NUM_CORES-1:0]  cmpIrq
);

  ctrlStrobe_t        strobe;
  logic [CORE_W-1:0]  tgtCore;
  logic [CORE_W-1:0]  peerRd;

  timebase_ctrl #(
    .NUM_CORES(NUM_CORES),
    .CORE_W   (CORE_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busCore  (busCore),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWrData(busWrData),
    .strobe   (strobe),
    .tgtCore  (tgtCore),
    .peerRd   (peerRd)
  );

  timebase_datapath #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W),
    .WIDTH_CODE(WIDTH_CODE)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .tgtCore(tgtCore),
    .peerRd (peerRd),
    .wrData (busWrData),
    .rdData (busRdData),
    .irq    (cmpIrq)
  );

endmodule

// File: tb/tb_shared_timebase.sv
module tb_shared_timebase;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busCore = '0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] narrowRdData;
  logic [3:0]  cmpIrq;
  logic [3:0]  narrowIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] heldC;

  always #5 clk = ~clk;

  shared_timebase #(.NUM_CORES(4), .WIDTH_CODE(8)) dut (
    .clk(clk), .rstN(rstN), .busCore(busCore), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData), .cmpIrq(cmpIrq));

  shared_timebase #(.NUM_CORES(4), .WIDTH_CODE(0)) dutNarrow (
    .clk(clk), .rstN(rstN), .busCore(busCore), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRdData(narrowRdData), .cmpIrq(narrowIrq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] core, input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    busCore = core; busAddr = addr; busWrData = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] core, input logic [2:0] addr, output logic [31:0] data);
    busCore = core; busAddr = addr;
    #1;
    data = busRdData;
  endtask

  task automatic testReset;
    logic [31:0] v;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead(0, 3'd1, v);             check("R1 count one cycle after reset", v, 32'd1);
    busRead(0, 3'd0, v);             check("R1 R4 cfg after reset", v, 32'h80);
    busCore = 0; busAddr = 3'd0; #1; check("R4 narrow width code", narrowRdData, 32'h0);
    busRead(1, 3'd3, v);             check("R1 cmp lo reset", v, 32'hFFFF_FFFF);
    busRead(1, 3'd4, v);             check("R1 cmp hi reset", v, 32'hFFFF_FFFF);
    busRead(2, 3'd5, v);             check("R1 peer select reset", v, 32'd0);
    check("R1 irq low after reset", {28'd0, cmpIrq}, 32'd0);
  endtask

  task automatic testCount;
    logic [31:0] a, b;
    @(negedge clk);
    busRead(0, 3'd1, a);
    repeat (7) @(negedge clk);
    busRead(0, 3'd1, b);
    check("R2 seven cycles advance", b - a, 32'd7);
    busAddr = 3'd1; #1;
    check("R3 narrow low word tracks wide", narrowRdData, busRdData);
    busAddr = 3'd2; #1;
    check("R3 narrow upper word zero", narrowRdData, 32'd0);
  endtask

  task automatic testHalt;
    logic [31:0] a, b;
    busWrite(0, 3'd0, 32'd1);
    busRead(0, 3'd1, a);
    repeat (10) @(negedge clk);
    busRead(0, 3'd1, b);
    check("R5 count holds while halted", b, a);
    busRead(0, 3'd0, b);
    check("R4 halt bit reads back", b, 32'h81);
    busWrite(0, 3'd0, 32'hFFFF_FFF1);
    busRead(0, 3'd0, b);
    check("R4 read-only cfg bits", b, 32'h81);
    busWrite(1, 3'd1, 32'd0);
    busWrite(1, 3'd2, 32'd5);
    busRead(0, 3'd1, b);
    check("R10 low write ignored", b, a);
    busRead(0, 3'd2, b);
    check("R10 high write ignored", b, 32'd0);
    busWrite(0, 3'd0, 32'd0);
    repeat (10) @(negedge clk);
    busRead(0, 3'd1, b);
    check("R5 resumes from held value", b, a + 32'd10);
    busWrite(0, 3'd0, 32'd1);
    busRead(0, 3'd1, heldC);
  endtask

  task automatic testLocalCmp;
    logic [31:0] v;
    busWrite(2, 3'd4, 32'h1234_5678);
    busWrite(2, 3'd3, 32'h9ABC_DEF0);
    busRead(2, 3'd4, v);  check("R6 cmp hi readback", v, 32'h1234_5678);
    busRead(2, 3'd3, v);  check("R6 cmp lo readback", v, 32'h9ABC_DEF0);
    busRead(1, 3'd3, v);  check("R6 other core untouched", v, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 no irq for far compare", {28'd0, cmpIrq}, 32'd0);
  endtask

  task automatic testIrq;
    busWrite(1, 3'd4, 32'd0);
    busWrite(1, 3'd3, heldC + 32'd1);
    @(negedge clk);
    check("R8 below compare stays low", {31'd0, cmpIrq[1]}, 32'd0);
    busWrite(1, 3'd3, heldC);
    check("R9 low in cycle after lo write", {31'd0, cmpIrq[1]}, 32'd0);
    @(negedge clk);
    check("R8 equal raises irq", {31'd0, cmpIrq[1]}, 32'd1);
    busWrite(1, 3'd3, heldC - 32'd3);
    @(negedge clk);
    check("R8 greater-than raises irq", {31'd0, cmpIrq[1]}, 32'd1);
    busWrite(1, 3'd4, 32'd1);
    @(negedge clk);
    check("R9 hi write keeps irq", {31'd0, cmpIrq[1]}, 32'd1);
    busWrite(1, 3'd3, heldC);
    @(negedge clk);
    check("R9 lo write clears irq", {31'd0, cmpIrq[1]}, 32'd0);
    check("R8 only own line", {28'd0, cmpIrq}, 32'd0);
  endtask

  task automatic testPeer;
    logic [31:0] v;
    busWrite(0, 3'd5, 32'd3);
    busRead(0, 3'd5, v);  check("R7 peer select readback", v, 32'd3);
    busWrite(0, 3'd5, 32'd9);
    busRead(0, 3'd5, v);  check("R7 out-of-range select ignored", v, 32'd3);
    busWrite(0, 3'd7, 32'd0);
    busWrite(0, 3'd6, 32'd0);
    busRead(3, 3'd3, v);  check("R7 peer lo landed on core 3", v, 32'd0);
    busRead(3, 3'd4, v);  check("R7 peer hi landed on core 3", v, 32'd0);
    busRead(0, 3'd6, v);  check("R7 peer window readback", v, 32'd0);
    busRead(0, 3'd3, v);  check("R7 own cmp untouched", v, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 peer compare raises core 3", {28'd0, cmpIrq}, 32'h8);
    busWrite(0, 3'd6, 32'd0);
    check("R9 peer lo write clears", {31'd0, cmpIrq[3]}, 32'd0);
    @(negedge clk);
    check("R9 re-evaluates after clear", {31'd0, cmpIrq[3]}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testCount();
    testHalt();
    testLocalCmp();
    testIrq();
    testPeer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule